// File: doc/BRIEF.md
# Bit-Serial Multiplierless Dot-Product Engine

This block forms the inner product of K signed fractional inputs with K coefficients that are fixed when the design is elaborated. It uses no multipliers. One operand vector is accepted through a valid/ready handshake. The engine then spends N clock cycles walking the bit positions of all inputs together. In each cycle, the K bits of equal weight form an address into a table of precomputed coefficient sums. A shift-and-add accumulator folds the addressed table word into the running sum.

Each input is an N-bit two's-complement fraction. Its leading bit carries weight -1 and the bit after it carries weight 2^-1, and so on down. Each coefficient is a 16-bit Q1.15 constant. The bit slices are consumed least-significant first, so the slice made of the sign bits is handled last, and on that cycle its table word is subtracted instead of added. The result is exact and full precision: the integer sum of coefficient times input integer, with weight 2^-(15+N-1).

The input side obeys valid/ready. A vector transfers only on a cycle where both `in_valid` and `in_ready` are high. `in_ready` stays low while a computation runs, so a valid offered then is not taken and has no effect; the caller holds back or retries. The output side has no back-pressure. `out_valid` is a one-cycle strobe, and `out_result` holds its value until the next completion.

Top module: `da_dot_product`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `out_result` is 0.
- R2: `in_ready` falls on the cycle after a transfer and stays low until the completion strobe. A valid that is offered while `in_ready` is low is not taken and does not change the result of the run in progress.
- R3: `out_valid` is high for exactly one cycle. It is asserted N clock edges after the edge at which the vector was taken.
- R4: `out_result` equals sum over k of C_k * X_k as a signed RW-bit integer. C_k is coefficient k as a signed 16-bit integer, taken from bits [16k+15:16k] of `COEFS`. X_k is the signed N-bit integer in bits [kN+N-1:kN] of `in_data`.
- R5: The table word for a bit slice is the sum of the coefficients whose input has a 1 in that bit. Bit k of the address is taken from input k, so an input vector with X_k = 1 and all other inputs 0 gives C_k.
- R6: The sign-bit slice is subtracted. An input equal to -2^(N-1), whose only set bit is the sign bit, contributes -C_k * 2^(N-1).
- R7: `out_result` changes only on the cycle where `out_valid` is high, and otherwise holds its value.
- R8: `in_ready` is high on the completion cycle, so a new vector can transfer on that cycle and the runs follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand vector offered |
| in_ready | output | 1 | Engine idle, can take a vector |
| in_data | input | K*N | K packed two's-complement inputs, input k at bits [kN+N-1:kN] |
| out_valid | output | 1 | One-cycle completion strobe |
| out_result | output | RW | Signed exact dot product, RW = 16+N+clog2(K)+1 |

## Verification
A result is due N edges after the edge at which its vector transferred. The driver computes the due cycle from a free-running edge counter and queues it with the reference value. The monitor samples on falling edges. It checks that each strobe arrives in the cycle that was queued and carries the exact integer reference, and that the engine is ready again in that same cycle. Ignored offers are made mid-run, and then the held result and the next completion are checked for any disturbance.

// File: rtl/da_pkg.sv
package da_pkg;
  localparam int COEF_BUS_MAX = 256;

  // signed coefficient idx from a packed bus of cw-bit fields
  function automatic int signed coef_at(logic [COEF_BUS_MAX-1:0] bus, int idx, int cw);
    logic [COEF_BUS_MAX-1:0] sh;
    int signed v;
    sh = bus >> (idx * cw);
    v  = int'(sh[31:0]);
    v  = (v <<< (32 - cw)) >>> (32 - cw);
    return v;
  endfunction

  // sum of the coefficients selected by the set bits of addr
  function automatic int signed slice_sum(int unsigned addr, logic [COEF_BUS_MAX-1:0] bus,
                                          int kn, int cw);
    int signed s;
    s = 0;
    for (int k = 0; k < kn; k++) begin
      if (((addr >> k) & 1) == 1) s += coef_at(bus, k, cw);
    end
    return s;
  endfunction
endpackage

// File: rtl/da_table.sv
module da_table #(
  parameter int K = 4,
  parameter int CW = 16,
  parameter int TW = 19,
  parameter logic [K*CW-1:0] COEFS = '0
) (
  input  logic [K-1:0]          addr,
  output logic signed [TW-1:0]  word
);
  localparam int DEPTH = 1 << K;
  localparam logic [da_pkg::COEF_BUS_MAX-1:0] BUS = da_pkg::COEF_BUS_MAX'(COEFS);

  logic signed [TW-1:0] rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    localparam int signed V = da_pkg::slice_sum(a, BUS, K, CW);
    assign rom[a] = TW'(V);
  end

  assign word = rom[addr];
endmodule

// File: rtl/da_slice_shifter.sv
module da_slice_shifter #(
  parameter int K = 4,
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           shift,
  input  logic [K*N-1:0] x_in,
  output logic [K-1:0]   slice
);
  for (genvar k = 0; k < K; k++) begin : g_lane
    logic [N-1:0] sr;
    always_ff @(posedge clk) begin
      if (!rst_n)     sr <= '0;
      else if (load)  sr <= x_in[k*N +: N];
      else if (shift) sr <= {1'b0, sr[N-1:1]};
    end
    assign slice[k] = sr[0];
  end
endmodule

// File: rtl/da_accum.sv
module da_accum #(
  parameter int TW = 19,
  parameter int N  = 8,
  parameter int RW = 27,
  parameter int AW = 36
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 step,
  input  logic                 sign_step,
  input  logic signed [TW-1:0] word,
  output logic [RW-1:0]        result
);
  logic signed [AW-1:0] acc, ext, addend, sum, nxt;

  always_comb begin
    ext    = {{(AW-TW){word[TW-1]}}, word};
    addend = ext <<< N;
    sum    = sign_step ? (acc - addend) : (acc + addend);
    nxt    = sum >>> 1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      result <= '0;
    end else begin
      if (clear)     acc <= '0;
      else if (step) acc <= nxt;
      if (step && sign_step) result <= RW'(nxt);
    end
  end

  // R4: the right shift drops only zero bits, so the sum stays exact
  p_exact_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !sum[0]);
  // R4: the final sum fits in the result width
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sign_step) |-> ((nxt[AW-1:RW-1] == '0) || (nxt[AW-1:RW-1] == '1)));
endmodule

// File: rtl/da_dot_product.sv
module da_dot_product #(
  parameter int K  = 4,
  parameter int N  = 8,
  parameter int CW = 16,
  parameter logic [K*CW-1:0] COEFS = {16'h0E14, 16'h799A, 16'hD99A, 16'h5C29},
  localparam int RW = CW + N + $clog2(K) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [K*N-1:0] in_data,
  output logic           out_valid,
  output logic [RW-1:0]  out_result
);
  localparam int TW    = CW + $clog2(K) + 1;
  localparam int AW    = RW + N + 1;
  localparam int CNT_W = (N > 2) ? $clog2(N) : 1;

  logic             busy, done, accept, last;
  logic [CNT_W-1:0] cnt;
  logic [K-1:0]     slice;
  logic signed [TW-1:0] word;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign last     = busy && (cnt == CNT_W'(N-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end

  da_slice_shifter #(.K(K), .N(N)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .shift(busy),
    .x_in(in_data), .slice(slice)
  );

  da_table #(.K(K), .CW(CW), .TW(TW), .COEFS(COEFS)) u_table (
    .addr(slice), .word(word)
  );

  da_accum #(.TW(TW), .N(N), .RW(RW), .AW(AW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(accept), .step(busy),
    .sign_step(last), .word(word), .result(out_result)
  );

  assign out_valid = done;

  // R2: after a transfer the engine is busy
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  // R3: completion strobe lasts one cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R6: completion follows the sign-slice cycle
  p_done_after_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(last));
  // R7: result holds between completions
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_result));
  // R8: ready on the completion cycle
  p_ready_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
endmodule

// File: tb/da_dot_product_tb.sv
module da_dot_product_tb;
  localparam int CLK_PERIOD = 10;
  localparam int K  = 4;
  localparam int N  = 8;
  localparam int CW = 16;
  localparam int RW = CW + N + $clog2(K) + 1;
  localparam logic [K*CW-1:0] COEFS = {16'h0E14, 16'h799A, 16'hD99A, 16'h5C29};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [K*N-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [RW-1:0] out_result;

  da_dot_product #(.K(K), .N(N), .CW(CW), .COEFS(COEFS)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_result(out_result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { longint val; int due; string tag; } exp_t;
  exp_t sb[$];
  int cyc = 0;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint coef(int k);
    logic [CW-1:0] c;
    c = COEFS[k*CW +: CW];
    return longint'($signed(c));
  endfunction

  function automatic longint ref_dot(logic [K*N-1:0] d);
    longint s = 0;
    for (int k = 0; k < K; k++) begin
      logic [N-1:0] e;
      e = d[k*N +: N];
      s += coef(k) * longint'($signed(e));
    end
    return s;
  endfunction

  function automatic logic [K*N-1:0] fill(logic [N-1:0] e);
    logic [K*N-1:0] d;
    for (int k = 0; k < K; k++) d[k*N +: N] = e;
    return d;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // driver: called at a falling edge
  task automatic send(logic [K*N-1:0] d, string tag);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    sb.push_back('{ref_dot(d), cyc + 1 + N, tag});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R3 strobe with nothing pending", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(longint'($signed(out_result)) == e.val, e.tag,
              longint'($signed(out_result)), e.val);
        check(cyc == e.due, "R3 completion cycle", cyc, e.due);
        check(in_ready, "R8 ready on completion cycle", in_ready, 1);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    logic [RW-1:0] held;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid at reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready at reset", in_ready, 1);
    check(out_result == '0, "R1 result at reset", longint'(out_result), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: single inputs of value 1 pick one coefficient each
    for (int k = 0; k < K; k++) begin
      logic [K*N-1:0] d;
      d = '0;
      d[k*N] = 1'b1;
      send(d, "R5 single coefficient slice");
    end
    send(fill(N'(1)), "R5 all-ones slice");

    // R6: sign slice subtracted
    send(fill({1'b1, {(N-1){1'b0}}}), "R6 all inputs -1");
    send(fill({N{1'b1}}), "R6 all inputs minus one lsb");
    send(fill({1'b0, {(N-1){1'b1}}}), "R4 all inputs max positive");

    // R2: offer during a run is ignored
    send(fill(N'(8'h35)), "R2 run with ignored offer");
    check(in_ready == 1'b0, "R2 busy after transfer", in_ready, 0);
    held = out_result;
    in_valid = 1'b1;
    in_data  = fill(N'(8'hC3));
    @(negedge clk);
    in_valid = 1'b0;
    check(out_result == held, "R7 result held across ignored offer",
          longint'(out_result), longint'(held));

    // R4 / R8: random vectors, back to back
    for (int i = 0; i < 40; i++) begin
      send(K*N'($urandom()), "R4 random vector");
    end

    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    held = out_result;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(out_result == held, "R7 result stable while idle",
            longint'(out_result), longint'(held));
    end
    finish_run();
  end
endmodule